// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM of 512K words by 8 bits. A client hands over one word at a time on a valid/ready handshake that carries an address, write data and a read/write flag. The controller drives the memory's active-low chip select, output enable and write strobe, a 19-bit address bus and a tri-stated 8-bit data bus. Each strobe phase lasts a whole number of clock cycles. That count comes from nanosecond timing parameters and the clock period: the phase time divided by the period and rounded up, with at least one cycle per phase.

A read selects the chip with output enable low and the write strobe high. It samples the bus once the address access time, the chip-select access time, the output-enable access time and the minimum read cycle have all elapsed, then returns the word with a one-cycle valid pulse. A write keeps output enable high throughout. It first presents the address with the chip selected. It then drives the data and lowers the write strobe for the pulse width, raises the strobe, and holds address and data for one more cycle. Before driving the bus after a read, the controller waits out the memory's output float time. Between transfers the chip is deselected so that it sits in standby.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and right after it: sram_ce_n, sram_oe_n and sram_we_n are 1, rdata_valid is 0, req_ready is 1 and the controller does not drive sram_dq.
- R2: Whenever req_ready is 1 (no transfer in progress), sram_ce_n is 1 (standby).
- R3: A read (req_we=0) drives sram_ce_n=0, sram_oe_n=0 and sram_we_n=1 with sram_addr equal to req_addr. rdata_valid rises for exactly one cycle RD_CYC rising edges after the accepting edge. RD_CYC is the largest of ceil(T_RC_NS/CLK_PERIOD_NS), ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_ACE_NS/CLK_PERIOD_NS) and ceil(T_DOE_NS/CLK_PERIOD_NS), and is 4 with the defaults.
- R4: rdata equals the memory contents at the read address and holds that value until the next read completes.
- R5: A write (req_we=1) holds sram_we_n at 0 for exactly WP_CYC = ceil(T_PWE_NS/CLK_PERIOD_NS) cycles (3 with the defaults), with sram_oe_n=1 and sram_ce_n=0. sram_dq carries req_wdata during that pulse and for one cycle after sram_we_n returns to 1.
- R6: The controller drives sram_dq only while sram_oe_n is 1, and only once sram_oe_n has been 1 for at least HZ_CYC = ceil(T_HZ_NS/CLK_PERIOD_NS) cycles (2 with the defaults).
- R7: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready stays 0 while a transfer is in progress.
- R8: A write followed by a read of the same address returns the written data, including for back-to-back transfers in either order.
- R9: sram_addr does not change while sram_ce_n stays 0.
- R10: During a write, sram_ce_n is 0 and the address is presented for at least one cycle before sram_we_n falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, able to accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_valid | output | 1 | One-cycle pulse, rdata is new |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_addr | output | 19 | Memory address bus |
| sram_dq | inout | 8 | Bidirectional data bus |

## Verification
The assertions check the following on every cycle:
- read and write strobes are never active together;
- the write strobe only falls after a cycle with the chip selected;
- the address never moves while the chip is selected;
- the chip is deselected whenever the controller is idle;
- the data bus is only driven with output enable high, and only after the float window has passed.

Only the bench scenarios can show the following against a behavioural memory:
- the exact read latency in cycles;
- the exact write pulse width;
- the value placed on the bus;
- the read data returned, in particular read-after-write and write-after-read back-to-back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WHOLD
  } sram_st_e;

  // cycles needed to cover ns, never fewer than one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_dq_io.sv
module sram_dq_io #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_d,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap,
  input  logic [DATA_W-1:0] dq_in,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe       <= 1'b0;
      rdata_valid <= 1'b0;
    end else begin
      dq_oe       <= drive_d;
      rdata_valid <= cap;
    end
  end

  always_ff @(posedge clk) begin
    dq_out <= wdata;
    if (cap) begin
      rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_ACE_NS      = 70,
  parameter int T_DOE_NS      = 35,
  parameter int T_HZ_NS       = 25,
  parameter int T_PWE_NS      = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq
);

  localparam int RD_CYC = max2(max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS), ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                               max2(ns_to_cyc(T_ACE_NS, CLK_PERIOD_NS), ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS)));
  localparam int WP_CYC = ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS);
  localparam int HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int CNT_W  = $clog2(max2(RD_CYC, WP_CYC) + 1);
  localparam int HZ_W   = $clog2(HZ_CYC + 1);

  sram_st_e          st, st_d;
  logic              ph_load, ph_zero, fl_load, fl_zero, cap, drive_d;
  logic [CNT_W-1:0]  ph_val;
  logic [DATA_W-1:0] wdata_q, dq_out;
  logic              dq_oe;

  // phase length counter for the strobe being held
  sram_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  // float window after output enable / chip select release
  sram_phase_timer #(.CNT_W(HZ_W)) u_float (
    .clk(clk), .rst(rst), .load(fl_load), .load_val(HZ_W'(HZ_CYC - 1)), .zero(fl_zero)
  );

  always_comb begin
    st_d    = st;
    ph_load = 1'b0;
    ph_val  = '0;
    fl_load = 1'b0;
    cap     = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          st_d    = req_we ? ST_WSET : ST_RD;
          ph_load = 1'b1;
          ph_val  = req_we ? '0 : CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD: begin
        if (ph_zero) begin
          cap     = 1'b1;
          fl_load = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_WSET: begin
        if (ph_zero && fl_zero) begin
          st_d    = ST_WPUL;
          ph_load = 1'b1;
          ph_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WPUL: begin
        if (ph_zero) begin
          st_d = ST_WHOLD;
        end
      end
      ST_WHOLD: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign drive_d   = (st_d == ST_WPUL) || (st_d == ST_WHOLD);
  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
    end else begin
      st        <= st_d;
      sram_ce_n <= (st_d == ST_IDLE);
      sram_oe_n <= (st_d != ST_RD);
      sram_we_n <= (st_d != ST_WPUL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      wdata_q   <= '0;
    end else if (req_ready && req_valid) begin
      sram_addr <= req_addr;
      wdata_q   <= req_wdata;
    end
  end

  sram_dq_io #(.DATA_W(DATA_W)) u_io (
    .clk(clk), .rst(rst), .drive_d(drive_d), .wdata(wdata_q), .cap(cap),
    .dq_in(sram_dq), .dq_oe(dq_oe), .dq_out(dq_out), .rdata(rdata), .rdata_valid(rdata_valid)
  );

  assign sram_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

  // cycles since output enable was last low, saturating
  logic [HZ_W-1:0] since_oe;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_oe <= HZ_W'(HZ_CYC);
    end else if (!sram_oe_n) begin
      since_oe <= '0;
    end else if (since_oe != HZ_W'(HZ_CYC)) begin
      since_oe <= since_oe + 1'b1;
    end
  end

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !sram_oe_n |-> (sram_we_n && !sram_ce_n)); // R3
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst) rdata_valid |-> $past(!sram_oe_n)); // R3
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst) !sram_we_n |-> (sram_oe_n && !sram_ce_n)); // R5
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst) dq_oe |-> sram_oe_n); // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst) $rose(dq_oe) |-> (since_oe >= HZ_W'(HZ_CYC))); // R6
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst) req_ready |-> sram_ce_n); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) !sram_ce_n |-> !req_ready); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R9
  AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (rst) $fell(sram_we_n) |-> $past(!sram_ce_n)); // R10

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int PER = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_RD = 4;
  localparam int EXP_WP = 3;
  localparam int EXP_HZ = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rdata_valid, sram_ce_n, sram_oe_n, sram_we_n;
  logic [7:0]  rdata;
  logic [18:0] sram_addr;
  wire  [7:0]  sram_dq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0]  exp_wd;
  logic [18:0] exp_a;

  always #(PER/2) clk = ~clk;

  sram_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .rdata_valid(rdata_valid),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_addr(sram_addr), .sram_dq(sram_dq)
  );

  // behavioural memory, low 8 address bits only
  assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : 8'bzzzzzzzz;

  always @(posedge sram_we_n) begin
    if (mon_on && !sram_ce_n) mem[sram_addr[7:0]] = sram_dq;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // per-cycle monitor
  int  since_b = 100;
  int  we_len = 0;
  bit  prev_we_low = 1'b0;
  bit  prev_ce_low = 1'b0;
  bit  prev_sel_no_we = 1'b0;
  logic [18:0] prev_addr = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (sram_oe_n) begin
        if (since_b < 100) since_b++;
      end else begin
        since_b = 0;
      end
      if (req_ready) chk(sram_ce_n, "R2", sram_ce_n, 1);
      if (!sram_ce_n && prev_ce_low) chk(sram_addr == prev_addr, "R9", sram_addr, prev_addr);
      if (!sram_we_n) begin
        if (!prev_we_low) begin
          chk(since_b >= EXP_HZ + 1, "R6", since_b, EXP_HZ + 1);
          chk(prev_sel_no_we, "R10", prev_sel_no_we, 1);
          chk(sram_addr == exp_a, "R5 addr", sram_addr, exp_a);
          we_len = 0;
        end
        we_len++;
        chk(sram_oe_n && !sram_ce_n, "R5 strobes", {sram_oe_n, sram_ce_n}, 2);
        chk(sram_dq == exp_wd, "R5 data", sram_dq, exp_wd);
      end else if (prev_we_low) begin
        chk(we_len == EXP_WP, "R5 width", we_len, EXP_WP);
        chk(sram_dq == exp_wd, "R5 hold", sram_dq, exp_wd);
      end
      if (!sram_oe_n) chk(sram_we_n && !sram_ce_n, "R3 strobes", {sram_we_n, sram_ce_n}, 2);
      prev_we_low    = !sram_we_n;
      prev_ce_low    = !sram_ce_n;
      prev_addr      = sram_addr;
      prev_sel_no_we = !sram_ce_n && sram_we_n;
    end
  end

  task automatic xfer(input logic w, input logic [18:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    if (w) begin
      exp_wd = d; exp_a = a;
    end
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7", req_ready, 0);
    if (w) begin
      shadow[a[7:0]] = d;
      n = 0;
      while (!req_ready && n < 50) begin @(negedge clk); n++; end
    end else begin
      chk(sram_addr == a, "R3 addr", sram_addr, a);
      n = 0;
      while (!rdata_valid && n < 50) begin @(negedge clk); n++; end
      chk(n == EXP_RD, "R3 latency", n, EXP_RD);
      chk(rdata == shadow[a[7:0]], "R4 R8 data", rdata, shadow[a[7:0]]);
      @(negedge clk);
      chk(!rdata_valid, "R3 pulse", rdata_valid, 0);
      chk(rdata == shadow[a[7:0]], "R4 held", rdata, shadow[a[7:0]]);
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED1);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    chk(cyc(70) == EXP_RD && cyc(45) == EXP_WP && cyc(25) == EXP_HZ, "R3 R5 R6 params", cyc(70), EXP_RD);
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    chk(!rdata_valid && req_ready, "R1 idle", {rdata_valid, req_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n && req_ready, "R1 after", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    mon_on = 1'b1;
    // directed corners
    xfer(1'b0, 19'h00010, 8'h00);
    xfer(1'b1, 19'h00000, 8'hFF);
    xfer(1'b0, 19'h00000, 8'h00);
    xfer(1'b1, 19'h7FFFF, 8'h00);
    xfer(1'b0, 19'h7FFFF, 8'h00);
    xfer(1'b1, 19'h12345, 8'hA5);
    xfer(1'b1, 19'h12345, 8'h3C);
    xfer(1'b0, 19'h12345, 8'h00);
    xfer(1'b0, 19'h12346, 8'h00);
    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [18:0] ra;
      ra = 19'($urandom);
      if ($urandom % 3 == 0) ra[7:0] = 8'($urandom % 4);
      xfer(1'($urandom), ra, 8'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    for (int k = 0; k < 4; k++) xfer(1'b0, 19'(k), 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PER * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule